// File: doc/BRIEF.md
# Nibble-Programmed Divider Word Bank

This block is the programming front end of a frequency synthesizer. A host puts a 4-bit nibble on the data lines and a 3-bit latch number on the address lines, then raises a strobe. Eight 4-bit latches sit behind the bus. A write to one latch leaves the other seven unchanged, so each divider word is built from several nibble writes. The latch contents are gathered into three counter words: a 7-bit swallow value A, a 10-bit main divide value N and a 12-bit reference divide value R.

Each latch is transparent at clock granularity. On every clock edge where the strobe is high, the addressed latch takes the data lines. When the strobe drops, the latch keeps the value it took on the last high cycle. The assembled words are registered. The reference word is forced up to the smallest legal divide ratio, and it drives a reference divider. That divider produces a one-clock reference pulse once every R clocks. It reloads at terminal count, so a new R never cuts short the period already running. When the R latches are all zero, the divider stays idle.

Top module: `div_prog_bank`

## Requirements
- R1: While reset is high and in the first cycle after it, a_word, n_word and r_word are 0 and fr_pulse is 0.
- R2: On a clock edge with stb high, the latch chosen by addr takes data, with data[3] as the most significant bit. The words reflect it on the second rising edge after that edge. Latches 0 and 1 give a_word, low nibble first, and bit 3 of latch 1 is dropped. Latches 2, 3 and 4 give n_word, low nibble first, and bits 3:2 of latch 4 are dropped. Latches 5, 6 and 7 give the raw R value, low nibble first.
- R3: If stb is held high for several cycles while data changes, the latch keeps the value present on the last high cycle. While stb is low, changes on data or addr have no effect.
- R4: A write to one latch leaves the bits that come from the other seven latches unchanged.
- R5: When the raw R value is 0, r_word is 0 and fr_pulse stays low.
- R6: A raw R value of 1 or 2 gives r_word = 3, and pulses come every 3 clocks.
- R7: A raw R value from 3 to 4095 gives r_word equal to that value. fr_pulse is then high for exactly one clock, and successive pulses are r_word clocks apart.
- R8: A new R value written during a reference period does not change that period. The period that follows the next pulse uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | Strobe; the addressed latch follows data while high |
| addr | input | 3 | Latch select |
| data | input | 4 | Nibble data, bit 3 most significant |
| a_word | output | 7 | Assembled swallow count A |
| n_word | output | 10 | Assembled main divide value N |
| r_word | output | 12 | Clamped reference divide value, 0 when idle |
| fr_pulse | output | 1 | One-clock reference pulse every r_word clocks |

## Verification
If a latch is corrupted or decoded wrongly, it shows up in the nibble position it feeds on a_word, n_word or r_word, two rising edges after the write that caused it. A fault in the divider's count or reload shows up as a wrong distance between fr_pulse edges in the first full period after the fault. A reload fault affects the period that straddles an R change. An idle-state fault shows as a pulse within a cycle of the R latches being zeroed. Random nibble writes, multi-cycle strobes and writes made with the strobe low are compared against a bench-side model of the latches. Directed runs cover the clamp, the largest ratio and a change of R in mid-period.

// File: rtl/div_prog_pkg.sv
package div_prog_pkg;
  localparam int DATA_W    = 4;
  localparam int ADDR_W    = 3;
  localparam int NUM_LATCH = 1 << ADDR_W;
  localparam int A_W       = 7;
  localparam int N_W       = 10;
  localparam int R_W       = 12;
  localparam int R_MIN     = 3;
  localparam int A_BASE    = 0;
  localparam int N_BASE    = 2;
  localparam int R_BASE    = 5;
endpackage

// File: rtl/nibble_latch_bank.sv
module nibble_latch_bank
  import div_prog_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NL = NUM_LATCH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic [NL*DW-1:0] flat
);
  // One storage nibble per address; a latch follows data on each edge
  // where it is selected and the strobe is high.
  for (genvar g = 0; g < NL; g++) begin : g_latch
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (stb && (addr == AW'(g))) begin
        q <= data;
      end
    end
    assign flat[g*DW +: DW] = q;
  end
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import div_prog_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NL    = NUM_LATCH,
  parameter int AWD   = A_W,
  parameter int NWD   = N_W,
  parameter int RWD   = R_W,
  parameter int RMIN  = R_MIN,
  parameter int ABASE = A_BASE,
  parameter int NBASE = N_BASE,
  parameter int RBASE = R_BASE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NL*DW-1:0] flat,
  output logic [AWD-1:0]   a_word,
  output logic [NWD-1:0]   n_word,
  output logic [RWD-1:0]   r_word
);
  localparam int A_PAD = (NBASE - ABASE) * DW - AWD;
  localparam int N_PAD = (RBASE - NBASE) * DW - NWD;

  logic [AWD-1:0] a_raw;
  logic [NWD-1:0] n_raw;
  logic [RWD-1:0] r_raw;
  logic [RWD-1:0] r_eff;
  logic           unused_pad;

  assign a_raw = flat[ABASE*DW +: AWD];
  assign n_raw = flat[NBASE*DW +: NWD];
  assign r_raw = flat[RBASE*DW +: RWD];
  assign unused_pad = ^{flat[ABASE*DW+AWD +: A_PAD], flat[NBASE*DW+NWD +: N_PAD]};

  always_comb begin
    if (r_raw == '0) begin
      r_eff = '0;
    end else if (r_raw < RWD'(RMIN)) begin
      r_eff = RWD'(RMIN);
    end else begin
      r_eff = r_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_word <= '0;
      n_word <= '0;
      r_word <= '0;
    end else begin
      a_word <= a_raw;
      n_word <= n_raw;
      r_word <= r_eff;
    end
  end
endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import div_prog_pkg::*;
#(
  parameter int RWD = R_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RWD-1:0] ratio,
  output logic           tick
);
  logic [RWD-1:0] cnt;
  logic           run;

  assign run = (ratio != '0);

  // Down counter: a terminal count fires the pulse and takes in the
  // ratio present at that moment, so a period is never shortened.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= ratio - RWD'(1);
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - RWD'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/div_prog_bank.sv
module div_prog_bank
  import div_prog_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int AWD  = A_W,
  parameter int NWD  = N_W,
  parameter int RWD  = R_W,
  parameter int RMIN = R_MIN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  data,
  output logic [AWD-1:0] a_word,
  output logic [NWD-1:0] n_word,
  output logic [RWD-1:0] r_word,
  output logic           fr_pulse
);
  localparam int NL = 1 << AW;

  logic [NL*DW-1:0] flat;

  nibble_latch_bank #(.DW(DW), .AW(AW), .NL(NL)) u_bank (
    .clk (clk),
    .rst (rst),
    .stb (stb),
    .addr(addr),
    .data(data),
    .flat(flat)
  );

  word_assembler #(
    .DW(DW), .NL(NL), .AWD(AWD), .NWD(NWD), .RWD(RWD), .RMIN(RMIN),
    .ABASE(A_BASE), .NBASE(N_BASE), .RBASE(R_BASE)
  ) u_asm (
    .clk   (clk),
    .rst   (rst),
    .flat  (flat),
    .a_word(a_word),
    .n_word(n_word),
    .r_word(r_word)
  );

  ref_divider #(.RWD(RWD)) u_div (
    .clk  (clk),
    .rst  (rst),
    .ratio(r_word),
    .tick (fr_pulse)
  );
endmodule

// File: rtl/div_prog_chk.sv
module div_prog_chk #(
  parameter int AWD  = 7,
  parameter int NWD  = 10,
  parameter int RWD  = 12,
  parameter int RMIN = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           stb,
  input logic [AWD-1:0] a_word,
  input logic [NWD-1:0] n_word,
  input logic [RWD-1:0] r_word,
  input logic           fr_pulse
);
  // R3: with no strobe two edges back, the assembled words do not move
  assert_hold_words_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(stb, 2) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
      |-> ($stable(a_word) && $stable(n_word) && $stable(r_word)));

  // R5: an idle ratio yields no pulse on the next edge
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (r_word == '0) |=> !fr_pulse);

  // R6: the ratio is either idle or at least the minimum
  assert_ratio_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (r_word == '0) || (r_word >= RWD'(RMIN)));

  // R7: the reference pulse lasts a single clock
  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
    fr_pulse |=> !fr_pulse);

  // R1: reset state one edge after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (a_word == '0 && n_word == '0 && r_word == '0 && !fr_pulse));
endmodule

bind div_prog_bank div_prog_chk #(.AWD(AWD), .NWD(NWD), .RWD(RWD), .RMIN(RMIN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .stb     (stb),
  .a_word  (a_word),
  .n_word  (n_word),
  .r_word  (r_word),
  .fr_pulse(fr_pulse)
);

// File: tb/div_prog_bank_tb.sv
module div_prog_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  data = '0;
  logic [6:0]  a_word;
  logic [9:0]  n_word;
  logic [11:0] r_word;
  logic        fr_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [3:0] model [8];

  always #2.5 clk = ~clk;

  div_prog_bank u_dut (
    .clk(clk), .rst(rst), .stb(stb), .addr(addr), .data(data),
    .a_word(a_word), .n_word(n_word), .r_word(r_word), .fr_pulse(fr_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [6:0] exp_a();
    return {model[1][2:0], model[0]};
  endfunction
  function automatic logic [9:0] exp_n();
    return {model[4][1:0], model[3], model[2]};
  endfunction
  function automatic logic [11:0] exp_r();
    logic [11:0] raw;
    raw = {model[7], model[6], model[5]};
    if (raw == 0) return 12'd0;
    if (raw < 3) return 12'd3;
    return raw;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_words(input string tag);
    chk({tag, " a_word"}, int'(a_word), int'(exp_a()));
    chk({tag, " n_word"}, int'(n_word), int'(exp_n()));
    chk({tag, " r_word"}, int'(r_word), int'(exp_r()));
  endtask

  // one strobe-high cycle, then strobe low; returns at the negedge after
  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; data = d; stb = 1'b1;
    model[a] = d;
    @(negedge clk);
    stb = 1'b0;
    addr = 3'($urandom); data = 4'($urandom);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_r(input logic [11:0] v);
    wr(3'd5, v[3:0]); wr(3'd6, v[7:4]); wr(3'd7, v[11:8]);
    settle();
  endtask

  task automatic wait_pulse(output int t);
    @(negedge clk);
    while (!fr_pulse) @(negedge clk);
    t = cyc;
  endtask

  task automatic gap_check(input string tag, input int exp);
    int t0, t1;
    wait_pulse(t0);
    wait_pulse(t1);
    chk(tag, t1 - t0, exp);
  endtask

  initial begin
    int t0, t1, t2, pulses;
    logic [2:0] a;
    logic [3:0] d;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 8; i++) model[i] = 4'd0;

    // R1: reset state, with the strobe active during reset
    stb = 1'b1; addr = 3'd5; data = 4'hF;
    repeat (5) @(negedge clk);
    chk_words("R1 in reset");
    chk("R1 fr in reset", int'(fr_pulse), 0);
    stb = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk_words("R1 after reset");
    chk("R1 fr after reset", int'(fr_pulse), 0);

    // R5: idle while raw R is zero
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (fr_pulse) pulses++;
    end
    chk("R5 idle pulses", pulses, 0);

    // R2: directed nibble placement
    wr(3'd0, 4'hA); wr(3'd1, 4'hF); settle();
    chk("R2 a_word drops bit3 of latch1", int'(a_word), 7'h7A);
    wr(3'd2, 4'h5); wr(3'd3, 4'hC); wr(3'd4, 4'hF); settle();
    chk("R2 n_word drops bits3:2 of latch4", int'(n_word), 10'h3C5);

    // R3: strobe held three cycles with changing data
    @(negedge clk);
    addr = 3'd3; stb = 1'b1; data = 4'h1;
    @(negedge clk); data = 4'h2;
    @(negedge clk); data = 4'h9;
    @(negedge clk); stb = 1'b0; data = 4'h6;
    model[3] = 4'h9;
    settle();
    chk_words("R3 last high cycle kept");

    // R3: bus noise while strobe low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      addr = 3'($urandom); data = 4'($urandom);
    end
    settle(); settle();
    chk_words("R3 strobe low ignored");

    // R6: clamp of 1 and 2
    set_r(12'd1);
    chk("R6 raw1 r_word", int'(r_word), 3);
    gap_check("R6 raw1 period", 3);
    set_r(12'd2);
    chk("R6 raw2 r_word", int'(r_word), 3);
    gap_check("R6 raw2 period", 3);

    // R7: exact values and periods
    set_r(12'd3);   gap_check("R7 period 3", 3);
    set_r(12'd17);  chk("R7 r_word 17", int'(r_word), 17); gap_check("R7 period 17", 17);
    set_r(12'd4095); chk("R7 r_word 4095", int'(r_word), 4095); gap_check("R7 period 4095", 4095);
    for (int k = 0; k < 6; k++) begin
      logic [11:0] rv;
      rv = 12'd3 + 12'($urandom_range(0, 250));
      set_r(rv);
      gap_check($sformatf("R7 random period %0d", rv), int'(rv));
    end

    // R8: change R in mid-period
    set_r(12'd40);
    wait_pulse(t0);
    wr(3'd5, 4'h9); wr(3'd6, 4'h0); wr(3'd7, 4'h0);
    wait_pulse(t1);
    wait_pulse(t2);
    chk("R8 running period keeps old R", t1 - t0, 40);
    chk("R8 next period uses new R", t2 - t1, 9);

    // R4: random writes, all other fields must stay
    for (int i = 0; i < 300; i++) begin
      a = 3'($urandom);
      d = 4'($urandom);
      wr(a, d);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        addr = 3'($urandom); data = 4'($urandom);
      end
      settle();
      chk_words("R4 random write");
    end

    // R5: zero the R latches, divider goes quiet
    set_r(12'd0);
    chk("R5 r_word zero", int'(r_word), 0);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fr_pulse) pulses++;
    end
    chk("R5 pulses after zero", pulses, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule